// File: doc/BRIEF.md
# Message Object Interrupt Tracker

This block keeps the interrupt bookkeeping for a bank of receive message objects inside a CAN acceptance and storage engine. A storage sequencer copies each accepted frame into its object over several write steps. The sequencer marks the opening step with a "first" strobe and the closing step with a "last" strobe, and each strobe carries a 6-bit object index. For every object the tracker holds four things: a pending flag, a lost flag, an interrupt enable written by software, and a two-bit semaphore that shows how far the update has progressed.

When the closing step of an update lands on an object whose enable is set, that object's pending flag rises. The lost flag is set or cleared at the opening step, and it copies whatever pending state earlier updates left behind. Software acknowledges an object by clearing its semaphore, and that clear also drops the pending flag. All pending flags are ORed into one interrupt line. Every flag can be read on the status outputs.

Top module: `msgobj_irq_tracker`

## Requirements
- R1: After synchronous active-high reset, every pending, lost, enable and semaphore bit is 0, and `irq_o` is 0.
- R2: A last strobe to object k sets `pend_o[k]` only when `ien_o[k]` is 1. With `ien_o[k]` at 0 the pending bit stays 0.
- R3: A first strobe to object k loads `lost_o[k]` with the value `pend_o[k]` had before that edge. A 1 there sets it and a 0 there clears it.
- R4: The semaphore of object k sits at `sem_o[2k+1:2k]`. It becomes 2'b01 on a first strobe and 2'b11 on a last strobe.
- R5: An accepted software clear of object k writes 2'b00 to its semaphore and clears `pend_o[k]`. It leaves `lost_o[k]` unchanged.
- R6: A software clear is ignored while object k is being written. That covers a semaphore of 2'b01 and a first strobe to k in the same cycle.
- R7: When the first and last strobes hit the same object in one cycle, the lost bit takes the pending value from before that cycle. The pending bit is then set (if enabled) and the semaphore becomes 2'b11.
- R8: When a software clear and a last strobe hit the same object in one cycle, the last strobe wins. Pending is set (if enabled) and the semaphore becomes 2'b11.
- R9: `irq_o` is the OR of all pending bits.
- R10: A strobe or clear changes only the object its index selects. Objects 0 and 63 are both reachable.
- R11: A pulse on `ien_we` loads all enables from `ien_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| first_vld | input | 1 | Opening write step of an object update |
| first_idx | input | 6 | Object index for the opening step |
| last_vld | input | 1 | Closing write step of an object update |
| last_idx | input | 6 | Object index for the closing step |
| clr_vld | input | 1 | Software semaphore-clear request |
| clr_idx | input | 6 | Object index for the clear |
| ien_we | input | 1 | Enable vector write strobe |
| ien_wdata | input | 64 | New interrupt enables, bit k for object k |
| ien_o | output | 64 | Current interrupt enables |
| pend_o | output | 64 | Pending flags |
| lost_o | output | 64 | Message-lost flags |
| sem_o | output | 128 | Semaphores, two bits per object |
| irq_o | output | 1 | OR of all pending flags |

## Verification
Every status bit is a single register. A strobe, clear or enable write sampled at one rising edge therefore shows up on `pend_o`, `lost_o`, `sem_o` and `ien_o` right after that same edge. In the default build `irq_o` follows the pending register with no extra delay. The bench drives each stimulus at a falling edge and holds it for exactly one rising edge. It compares all outputs against its own expected vectors at the next falling edge, one cycle after the stimulus, and removes the stimulus before the following edge so that no request is counted twice.

// File: rtl/msgobj_irq_pkg.sv
package msgobj_irq_pkg;

   typedef enum logic [1:0] {
      SEM_IDLE = 2'b00,
      SEM_BUSY = 2'b01,
      SEM_DONE = 2'b11
   } sem_e;

   localparam int SEM_W = 2;

endpackage

// File: rtl/msgobj_idx_dec.sv
module msgobj_idx_dec #(
   parameter int NUM_OBJ = 64,
   localparam int IDX_W = $clog2(NUM_OBJ)
) (
   input  logic               vld,
   input  logic [IDX_W-1:0]   idx,
   output logic [NUM_OBJ-1:0] hit
);

   generate
      if (NUM_OBJ < 2) begin : g_bad
         $error("msgobj_idx_dec: NUM_OBJ must be at least 2");
      end
   endgenerate

   for (genvar i = 0; i < NUM_OBJ; i++) begin : g_hit
      assign hit[i] = vld && (idx == IDX_W'(i));
   end

   // R10
   always_comb begin
      hit_onehot_chk : assert ($onehot0(hit));
   end

endmodule

// File: rtl/msgobj_cell.sv
module msgobj_cell
   import msgobj_irq_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             first_hit,
   input  logic             last_hit,
   input  logic             clr_hit,
   input  logic             ien_we,
   input  logic             ien_d,
   output logic             ien_q,
   output logic             pend_q,
   output logic             lost_q,
   output logic [SEM_W-1:0] sem_q
);

   logic busy;
   logic clr_ok;
   logic set_ok;

   assign busy   = (sem_q == SEM_BUSY) || first_hit;
   assign clr_ok = clr_hit && !busy;
   assign set_ok = last_hit && ien_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ien_q <= 1'b0;
      end else if (ien_we) begin
         ien_q <= ien_d;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q <= 1'b0;
      end else if (set_ok) begin
         pend_q <= 1'b1;
      end else if (clr_ok) begin
         pend_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         lost_q <= 1'b0;
      end else if (first_hit) begin
         lost_q <= pend_q;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sem_q <= SEM_IDLE;
      end else if (last_hit) begin
         sem_q <= SEM_DONE;
      end else if (first_hit) begin
         sem_q <= SEM_BUSY;
      end else if (clr_ok) begin
         sem_q <= SEM_IDLE;
      end
   end

   // R2
   pend_set_chk : assert property (@(posedge clk) disable iff (rst)
      (last_hit && ien_q) |=> pend_q);

   // R2
   pend_gated_chk : assert property (@(posedge clk) disable iff (rst)
      (!ien_q && !pend_q) |=> !pend_q);

   // R3
   lost_copy_chk : assert property (@(posedge clk) disable iff (rst)
      first_hit |=> (lost_q == $past(pend_q)));

   // R4
   sem_last_chk : assert property (@(posedge clk) disable iff (rst)
      last_hit |=> (sem_q == SEM_DONE));

   // R5
   clr_take_chk : assert property (@(posedge clk) disable iff (rst)
      (clr_hit && !first_hit && !last_hit && sem_q != SEM_BUSY)
      |=> (sem_q == SEM_IDLE && !pend_q && $stable(lost_q)));

   // R6
   clr_block_chk : assert property (@(posedge clk) disable iff (rst)
      (clr_hit && sem_q == SEM_BUSY && !first_hit && !last_hit)
      |=> ($stable(sem_q) && $stable(pend_q)));

endmodule

// File: rtl/msgobj_irq_or.sv
module msgobj_irq_or #(
   parameter int NUM_OBJ = 64,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_OBJ-1:0] pend,
   output logic               irq
);

   logic any_pend;
   assign any_pend = |pend;

   generate
      if (IRQ_REG) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (rst) irq_q <= 1'b0;
            else     irq_q <= any_pend;
         end
         assign irq = irq_q;
      end else begin : g_comb
         assign irq = any_pend;
      end
   endgenerate

endmodule

// File: rtl/msgobj_irq_tracker.sv
module msgobj_irq_tracker
   import msgobj_irq_pkg::*;
#(
   parameter int NUM_OBJ = 64,
   parameter bit IRQ_REG = 1'b0,
   localparam int IDX_W = $clog2(NUM_OBJ)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     first_vld,
   input  logic [IDX_W-1:0]         first_idx,
   input  logic                     last_vld,
   input  logic [IDX_W-1:0]         last_idx,
   input  logic                     clr_vld,
   input  logic [IDX_W-1:0]         clr_idx,
   input  logic                     ien_we,
   input  logic [NUM_OBJ-1:0]       ien_wdata,
   output logic [NUM_OBJ-1:0]       ien_o,
   output logic [NUM_OBJ-1:0]       pend_o,
   output logic [NUM_OBJ-1:0]       lost_o,
   output logic [SEM_W*NUM_OBJ-1:0] sem_o,
   output logic                     irq_o
);

   generate
      if ((1 << IDX_W) != NUM_OBJ) begin : g_pow2
         $error("msgobj_irq_tracker: NUM_OBJ must be a power of two");
      end
   endgenerate

   logic [NUM_OBJ-1:0] first_hit;
   logic [NUM_OBJ-1:0] last_hit;
   logic [NUM_OBJ-1:0] clr_hit;

   msgobj_idx_dec #(.NUM_OBJ(NUM_OBJ)) u_dec_first (
      .vld(first_vld), .idx(first_idx), .hit(first_hit));
   msgobj_idx_dec #(.NUM_OBJ(NUM_OBJ)) u_dec_last (
      .vld(last_vld), .idx(last_idx), .hit(last_hit));
   msgobj_idx_dec #(.NUM_OBJ(NUM_OBJ)) u_dec_clr (
      .vld(clr_vld), .idx(clr_idx), .hit(clr_hit));

   for (genvar k = 0; k < NUM_OBJ; k++) begin : g_obj
      msgobj_cell u_cell (
         .clk       (clk),
         .rst       (rst),
         .first_hit (first_hit[k]),
         .last_hit  (last_hit[k]),
         .clr_hit   (clr_hit[k]),
         .ien_we    (ien_we),
         .ien_d     (ien_wdata[k]),
         .ien_q     (ien_o[k]),
         .pend_q    (pend_o[k]),
         .lost_q    (lost_o[k]),
         .sem_q     (sem_o[SEM_W*k +: SEM_W]));
   end

   msgobj_irq_or #(.NUM_OBJ(NUM_OBJ), .IRQ_REG(IRQ_REG)) u_or (
      .clk(clk), .rst(rst), .pend(pend_o), .irq(irq_o));

   // R9
   generate
      if (!IRQ_REG) begin : g_irq_chk
         irq_or_chk : assert property (@(posedge clk) disable iff (rst)
            irq_o == (pend_o != '0));
      end
   endgenerate

   // R11
   ien_load_chk : assert property (@(posedge clk) disable iff (rst)
      ien_we |=> (ien_o == $past(ien_wdata)));

   // R1
   reset_clean_chk : assert property (@(posedge clk)
      $past(rst) |-> (pend_o == '0 && lost_o == '0 && sem_o == '0));

endmodule

// File: tb/msgobj_irq_tracker_bench.sv
module msgobj_irq_tracker_bench;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         first_vld = 1'b0, last_vld = 1'b0, clr_vld = 1'b0;
   logic [5:0]   first_idx = '0, last_idx = '0, clr_idx = '0;
   logic         ien_we = 1'b0;
   logic [63:0]  ien_wdata = '0;
   logic [63:0]  ien_o, pend_o, lost_o;
   logic [127:0] sem_o;
   logic         irq_o;

   logic [63:0]  e_ien = '0, e_pend = '0, e_lost = '0;
   logic [127:0] e_sem = '0;
   int           n_chk = 0;
   int           n_bad = 0;
   bit           done = 1'b0;

   always #10 clk = ~clk;

   msgobj_irq_tracker u_msgobj_irq_tracker (
      .clk(clk), .rst(rst),
      .first_vld(first_vld), .first_idx(first_idx),
      .last_vld(last_vld), .last_idx(last_idx),
      .clr_vld(clr_vld), .clr_idx(clr_idx),
      .ien_we(ien_we), .ien_wdata(ien_wdata),
      .ien_o(ien_o), .pend_o(pend_o), .lost_o(lost_o),
      .sem_o(sem_o), .irq_o(irq_o));

   task automatic check(input string tag, input logic [127:0] act,
                        input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic cmp_all(input string tag);
      check({tag, " pend"}, 128'(pend_o), 128'(e_pend));
      check({tag, " lost"}, 128'(lost_o), 128'(e_lost));
      check({tag, " sem"},  sem_o, e_sem);
      check({tag, " ien"},  128'(ien_o), 128'(e_ien));
      check({tag, " irq R9"}, 128'(irq_o), 128'(e_pend != '0));
   endtask

   task automatic set_sem(input int k, input logic [1:0] v);
      e_sem[2*k +: 2] = v;
   endtask

   task automatic step(input bit f, input int fi, input bit l, input int li,
                       input bit c, input int ci);
      first_vld = f; first_idx = 6'(fi);
      last_vld  = l; last_idx  = 6'(li);
      clr_vld   = c; clr_idx   = 6'(ci);
      @(posedge clk);
      @(negedge clk);
      first_vld = 1'b0; last_vld = 1'b0; clr_vld = 1'b0;
   endtask

   task automatic write_ien(input logic [63:0] v);
      ien_we = 1'b1; ien_wdata = v;
      @(posedge clk);
      @(negedge clk);
      ien_we = 1'b0;
      e_ien = v;
   endtask

   task automatic t_reset();
      cmp_all("R1 reset");
   endtask

   task automatic t_normal();
      write_ien('1);
      cmp_all("R11 enable load");
      step(1, 5, 0, 0, 0, 0);
      set_sem(5, 2'b01);
      cmp_all("R4 first sem");
      step(0, 0, 1, 5, 0, 0);
      set_sem(5, 2'b11); e_pend[5] = 1'b1;
      cmp_all("R2 last sets pending");
      step(0, 0, 0, 0, 1, 5);
      set_sem(5, 2'b00); e_pend[5] = 1'b0;
      cmp_all("R5 clear");
   endtask

   task automatic t_lost();
      step(1, 63, 0, 0, 0, 0); set_sem(63, 2'b01);
      step(0, 0, 1, 63, 0, 0); set_sem(63, 2'b11); e_pend[63] = 1'b1;
      cmp_all("R10 top object");
      step(1, 63, 0, 0, 0, 0); set_sem(63, 2'b01); e_lost[63] = 1'b1;
      cmp_all("R3 lost set");
      step(0, 0, 0, 0, 1, 63);
      cmp_all("R6 clear while busy");
      step(0, 0, 1, 63, 0, 0); set_sem(63, 2'b11);
      step(0, 0, 0, 0, 1, 63); set_sem(63, 2'b00); e_pend[63] = 1'b0;
      cmp_all("R5 clear keeps lost");
      step(1, 63, 0, 0, 0, 0); set_sem(63, 2'b01); e_lost[63] = 1'b0;
      cmp_all("R3 lost cleared");
      step(0, 0, 1, 63, 0, 0); set_sem(63, 2'b11); e_pend[63] = 1'b1;
      step(0, 0, 0, 0, 1, 63); set_sem(63, 2'b00); e_pend[63] = 1'b0;
      cmp_all("R5 object 63 idle");
   endtask

   task automatic t_disabled();
      write_ien(64'hFFFF_FFFF_FFFF_FFFE);
      cmp_all("R11 enable bit0 off");
      step(1, 0, 0, 0, 0, 0); set_sem(0, 2'b01);
      step(0, 0, 1, 0, 0, 0); set_sem(0, 2'b11);
      cmp_all("R2 disabled no pending");
      step(0, 0, 0, 0, 1, 0); set_sem(0, 2'b00);
      cmp_all("R10 object 0 clear");
   endtask

   task automatic t_same_cycle();
      step(1, 10, 1, 10, 0, 0); set_sem(10, 2'b11); e_pend[10] = 1'b1;
      cmp_all("R7 merged no lost");
      step(1, 10, 1, 10, 0, 0); e_lost[10] = 1'b1;
      cmp_all("R7 merged lost");
   endtask

   task automatic t_clr_race();
      step(0, 0, 1, 10, 1, 10);
      cmp_all("R8 last beats clear");
      step(1, 10, 0, 0, 1, 10); set_sem(10, 2'b01);
      cmp_all("R6 clear with first");
      step(0, 0, 1, 10, 0, 0); set_sem(10, 2'b11);
      step(0, 0, 0, 0, 1, 10); set_sem(10, 2'b00); e_pend[10] = 1'b0;
      cmp_all("R9 irq drops");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_normal();
      t_lost();
      t_disabled();
      t_same_cycle();
      t_clr_race();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog act=hung exp=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule